// File: doc/BRIEF.md
# Per-Lane Oversampled Deskew Calibrator

The block picks, for every serial data lane of a parallel-clocked link, the sampling phase that best centres the strobe on each bit. It works on sample vectors that were already captured at three samples per bit. Each clock it receives, per lane, a window of nine bit slots: one guard slot on each side of the seven-bit word. During a training run the transmitter repeats the slot 1111000 on every data lane. The calibrator scores seven candidate strobe positions per lane and keeps the centre of the widest group of positions that recover the training slot reliably.

Software or link control enables deskew with `deskew_en_i`. It raises `train_i` whenever the clock lane shows the training signature. Every lane runs its own search, so the skew between pairs is taken out one lane at a time. Until a lane has been trained, and for the whole of a training run, its recovered word is held at zero. `cal_o` reports that every lane has found a phase. With deskew off, the block reads every lane at the nominal strobe and does no search.

Top module: `deskew_calib`

## Requirements
- R1: Each lane's chosen phase depends only on that lane's own sample vector. Lanes with different skews end up at different phases after the same training run.
- R2: Lane l occupies `samples_i[27l+26:27l]`, with sample 0 earliest. At phase code p, word bit 6-k (MSB first) is read from sample 3k+4+p. The phase code is a signed count of thirds of a bit from -3 to +3, shown as 3-bit two's complement on `phase_o[3l+2:3l]`.
- R3: A candidate phase qualifies when the word recovered at that phase equals 1111000 on four consecutive clocks of one training run. Three consecutive matches are not enough.
- R4: On the first clock with `train_i` low after a run, each lane takes the centre of the longest group of adjacent qualifying phases. For an even-length group this is the lower of the two middle phases; when two groups tie, the lowest one wins. The phase then stays fixed until the next run or until deskew is disabled.
- R5: While deskew is enabled and a lane is untrained or in a training run, that lane's word output is zero.
- R6: A lane with no qualifying phase sets its `lane_err_o` bit, keeps phase 0 and delivers data read at the nominal strobe.
- R7: `cal_o` is high only while every lane is locked without error. It is low during training and while deskew is disabled.
- R8: With `deskew_en_i` low, every phase is 0, no error bit is set, no calibration takes place and words are read at the nominal strobe.
- R9: A rise of (`deskew_en_i` and `train_i`) starts a new calibration run. The run drops any earlier result and also applies to a lane that had failed.
- R10: `word_o` is registered. It shows the word held in the samples present before the clock edge, read at the phase valid after that edge.
- R11: Under reset all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| deskew_en_i | input | 1 | Enables per-lane calibration |
| train_i | input | 1 | Training slot present on the clock lane |
| samples_i | input | NUM_LANES*27 | Oversampled window per lane |
| word_o | output | NUM_LANES*7 | Recovered word per lane |
| phase_o | output | NUM_LANES*3 | Selected phase code per lane |
| lane_err_o | output | NUM_LANES | Lane found no usable phase |
| cal_o | output | 1 | All lanes calibrated |

## Verification
The properties assume that `train_i` is raised only while `deskew_en_i` is high. They also assume that a training run starts with a rise of both signals, not with a long-held level at reset release. The stimulus follows these rules: it drops `train_i` before every change of the enable, and each run keeps the same per-lane skew and pattern from start to end. For data words, the bench sets each lane's skew within one third of a bit of the phase that lane is expected to hold. The recovered word is then fully determined by the requirements.

// File: rtl/deskew_pkg.sv
package deskew_pkg;
  typedef enum logic [2:0] {
    LS_BYPASS,
    LS_WAIT,
    LS_TRAIN,
    LS_LOCKED,
    LS_FAILED
  } lane_state_e;
endpackage

// File: rtl/dsk_word_pick.sv
module dsk_word_pick #(
  parameter int BITS = 7,
  parameter int OS   = 3
) (
  input  logic [(BITS+2)*OS-1:0]    samples_i,
  input  logic [$clog2(2*OS+1)-1:0] idx_i,
  output logic [BITS-1:0]           word_o
);
  localparam int SAMP_W = (BITS + 2) * OS;
  localparam int SI_W   = $clog2(SAMP_W);

  for (genvar k = 0; k < BITS; k++) begin : g_bit
    logic [SI_W-1:0] sel;
    // slot k, earliest first, lands on word bit BITS-1-k
    assign sel = SI_W'(OS * k + OS / 2) + SI_W'(idx_i);
    assign word_o[BITS-1-k] = samples_i[sel];
  end
endmodule

// File: rtl/dsk_phase_scan.sv
module dsk_phase_scan #(
  parameter int             BITS       = 7,
  parameter int             OS         = 3,
  parameter int             RUN_LEN    = 4,
  parameter logic [BITS-1:0] TRAIN_WORD = 7'b1111000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic                    count_i,
  input  logic [(BITS+2)*OS-1:0]  samples_i,
  output logic [2*OS:0]           pass_o
);
  localparam int NPH   = 2 * OS + 1;
  localparam int IDX_W = $clog2(NPH);
  localparam int CW    = $clog2(RUN_LEN + 1);

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [BITS-1:0] word;
    logic            match;
    logic [CW-1:0]   cnt_q, cnt_d;

    dsk_word_pick #(.BITS(BITS), .OS(OS)) i_pick (
      .samples_i(samples_i),
      .idx_i    (IDX_W'(p)),
      .word_o   (word)
    );

    assign match = (word == TRAIN_WORD);

    always_comb begin
      if (!match)                     cnt_d = '0;
      else if (cnt_q == CW'(RUN_LEN)) cnt_d = cnt_q;
      else                            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q     <= '0;
        pass_o[p] <= 1'b0;
      end else if (start_i) begin
        cnt_q     <= CW'(match);
        pass_o[p] <= 1'b0;
      end else if (count_i) begin
        cnt_q     <= cnt_d;
        pass_o[p] <= pass_o[p] | (cnt_d == CW'(RUN_LEN));
      end
    end
  end
endmodule

// File: rtl/dsk_run_center.sv
module dsk_run_center #(
  parameter int N = 7
) (
  input  logic [N-1:0]         pass_i,
  output logic                 found_o,
  output logic [$clog2(N)-1:0] center_o
);
  localparam int IDX_W = $clog2(N);

  always_comb begin
    int run;
    int best_len;
    int best_start;
    run        = 0;
    best_len   = 0;
    best_start = 0;
    for (int i = 0; i < N; i++) begin
      run = pass_i[i] ? run + 1 : 0;
      // strict compare keeps the lowest group on a tie
      if (run > best_len) begin
        best_len   = run;
        best_start = i - run + 1;
      end
    end
    found_o  = (best_len > 0);
    center_o = found_o ? IDX_W'(best_start + (best_len - 1) / 2) : '0;
  end
endmodule

// File: rtl/dsk_lane.sv
module dsk_lane
  import deskew_pkg::*;
#(
  parameter int             BITS       = 7,
  parameter int             OS         = 3,
  parameter int             RUN_LEN    = 4,
  parameter logic [BITS-1:0] TRAIN_WORD = 7'b1111000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic                         start_i,
  input  logic                         train_i,
  input  logic [(BITS+2)*OS-1:0]       samples_i,
  output logic [BITS-1:0]              word_o,
  output logic [$clog2(OS+1):0]        phase_o,
  output logic                         err_o,
  output logic                         locked_o
);
  localparam int NPH   = 2 * OS + 1;
  localparam int IDX_W = $clog2(NPH);
  localparam int PHW   = $clog2(OS + 1) + 1;
  localparam logic [IDX_W-1:0] CTR = IDX_W'(OS);

  lane_state_e      state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d, center;
  logic [NPH-1:0]   pass;
  logic             found, hold;
  logic [BITS-1:0]  word_d;

  dsk_phase_scan #(
    .BITS(BITS), .OS(OS), .RUN_LEN(RUN_LEN), .TRAIN_WORD(TRAIN_WORD)
  ) i_scan (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .count_i  (state_d == LS_TRAIN),
    .samples_i(samples_i),
    .pass_o   (pass)
  );

  dsk_run_center #(.N(NPH)) i_center (
    .pass_i  (pass),
    .found_o (found),
    .center_o(center)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    if (!en_i) begin
      state_d = LS_BYPASS;
      idx_d   = CTR;
    end else if (start_i) begin
      state_d = LS_TRAIN;
      idx_d   = CTR;
    end else if (state_q == LS_TRAIN && !train_i) begin
      state_d = found ? LS_LOCKED : LS_FAILED;
      idx_d   = found ? center : CTR;
    end else if (state_q == LS_BYPASS) begin
      state_d = LS_WAIT;
    end
  end

  assign hold = (state_d == LS_WAIT) || (state_d == LS_TRAIN);

  dsk_word_pick #(.BITS(BITS), .OS(OS)) i_out_pick (
    .samples_i(samples_i),
    .idx_i    (idx_d),
    .word_o   (word_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LS_BYPASS;
      idx_q   <= CTR;
      word_o  <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      word_o  <= hold ? '0 : word_d;
    end
  end

  assign phase_o  = PHW'(idx_q) - PHW'(OS);
  assign err_o    = (state_q == LS_FAILED);
  assign locked_o = (state_q == LS_LOCKED);
endmodule

// File: rtl/deskew_calib.sv
module deskew_calib #(
  parameter int             NUM_LANES  = 4,
  parameter int             BITS       = 7,
  parameter int             OS         = 3,
  parameter int             RUN_LEN    = 4,
  parameter logic [BITS-1:0] TRAIN_WORD = 7'b1111000
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    deskew_en_i,
  input  logic                                    train_i,
  input  logic [NUM_LANES*(BITS+2)*OS-1:0]        samples_i,
  output logic [NUM_LANES*BITS-1:0]               word_o,
  output logic [NUM_LANES*($clog2(OS+1)+1)-1:0]   phase_o,
  output logic [NUM_LANES-1:0]                    lane_err_o,
  output logic                                    cal_o
);
  localparam int SAMP_W = (BITS + 2) * OS;
  localparam int PHW    = $clog2(OS + 1) + 1;

  logic                 run_q, start;
  logic [NUM_LANES-1:0] locked;

  // a run begins on the rise of enable-and-training
  assign start = deskew_en_i & train_i & ~run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= 1'b0;
    else         run_q <= deskew_en_i & train_i;
  end

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    dsk_lane #(
      .BITS(BITS), .OS(OS), .RUN_LEN(RUN_LEN), .TRAIN_WORD(TRAIN_WORD)
    ) i_lane (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (deskew_en_i),
      .start_i  (start),
      .train_i  (train_i),
      .samples_i(samples_i[l*SAMP_W +: SAMP_W]),
      .word_o   (word_o[l*BITS +: BITS]),
      .phase_o  (phase_o[l*PHW +: PHW]),
      .err_o    (lane_err_o[l]),
      .locked_o (locked[l])
    );
  end

  assign cal_o = &locked;
endmodule

// File: rtl/deskew_calib_chk.sv
module deskew_calib_chk #(
  parameter int NUM_LANES = 4,
  parameter int BITS      = 7,
  parameter int OS        = 3
) (
  input logic                                  clk_i,
  input logic                                  rst_ni,
  input logic                                  deskew_en_i,
  input logic                                  train_i,
  input logic [NUM_LANES*BITS-1:0]             word_o,
  input logic [NUM_LANES*($clog2(OS+1)+1)-1:0] phase_o,
  input logic [NUM_LANES-1:0]                  lane_err_o,
  input logic                                  cal_o
);
  localparam int PHW = $clog2(OS + 1) + 1;

  assert_hold_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deskew_en_i && train_i) |=> (word_o == '0));

  assert_bypass_nominal_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !deskew_en_i |=> (phase_o == '0 && lane_err_o == '0));

  assert_cal_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!deskew_en_i || train_i) |=> !cal_o);

  assert_cal_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cal_o |-> (lane_err_o == '0));

  assert_phase_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (deskew_en_i && !train_i && cal_o) |=> $stable(phase_o));

  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
    assert_phase_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($signed(phase_o[l*PHW +: PHW]) <= $signed(PHW'(OS))) &&
      ($signed(phase_o[l*PHW +: PHW]) >= -$signed(PHW'(OS))));

    assert_err_nominal_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lane_err_o[l] |-> (phase_o[l*PHW +: PHW] == '0));
  end
endmodule

bind deskew_calib deskew_calib_chk #(
  .NUM_LANES(NUM_LANES), .BITS(BITS), .OS(OS)
) i_deskew_calib_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .deskew_en_i(deskew_en_i),
  .train_i    (train_i),
  .word_o     (word_o),
  .phase_o    (phase_o),
  .lane_err_o (lane_err_o),
  .cal_o      (cal_o)
);

// File: tb/test_deskew_calib.sv
`timescale 1ns/100ps
module test_deskew_calib;
  localparam int L  = 4;
  localparam int B  = 7;
  localparam int OS = 3;
  localparam int SW = (B + 2) * OS;
  localparam int PW = 3;
  localparam logic [B-1:0] TW = 7'b1111000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic train = 1'b0;
  logic [L*SW-1:0] samples = '0;
  logic [L*B-1:0]  word;
  logic [L*PW-1:0] phase;
  logic [L-1:0]    lerr;
  logic            cal;

  deskew_calib #(.NUM_LANES(L), .BITS(B), .OS(OS)) i_deskew_calib (
    .clk_i(clk), .rst_ni(rst_n), .deskew_en_i(en), .train_i(train),
    .samples_i(samples), .word_o(word), .phase_o(phase),
    .lane_err_o(lerr), .cal_o(cal)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [L*B-1:0]  w;
    logic [L*PW-1:0] ph;
    logic [L-1:0]    err;
    logic            cal;
  } exp_t;

  exp_t  exp_q[$];
  string req_q[$];
  int n_checks = 0, n_fail = 0;
  bit finished = 0;
  string cur_req = "R11";

  int skew[L];
  bit bad[L];
  int st[L];     // 0 bypass 1 wait 2 train 3 locked 4 failed
  int mph[L];
  int tlen = 0;
  bit mprev = 0;
  int cyc = 0;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [SW-1:0] build(logic [B-1:0] w, bit pre, bit post, int d);
    logic [SW-1:0] v;
    for (int s = 0; s < SW; s++) begin
      int slot;
      slot = ((s - d + 6) / 3) - 3;
      v[s] = (slot < 0) ? pre : (slot >= B) ? post : w[B-1-slot];
    end
    return v;
  endfunction

  task automatic drive(bit e, bit t);
    logic [B-1:0] dw[L];
    bit start;
    exp_t it;
    @(negedge clk);
    cyc++;
    en = e;
    train = t;
    for (int l = 0; l < L; l++) begin
      if (t) begin
        dw[l] = bad[l] ? '0 : TW;
        samples[l*SW +: SW] = build(dw[l], 1'b0, !bad[l], skew[l]);
      end else begin
        dw[l] = B'((cyc * 37 + l * 23 + 5) % 128);
        samples[l*SW +: SW] = build(dw[l], 1'b0, 1'b0, skew[l]);
      end
    end
    start = e && t && !mprev;
    mprev = e && t;
    if (start) tlen = 1;
    else if (e && t) tlen++;
    for (int l = 0; l < L; l++) begin
      if (!e) begin st[l] = 0; mph[l] = 0; end
      else if (start) begin st[l] = 2; mph[l] = 0; end
      else if (st[l] == 2 && !t) begin
        if (!bad[l] && tlen >= 4) begin
          int lo, hi;
          lo = (skew[l] - 1 < -3) ? -3 : skew[l] - 1;
          hi = (skew[l] + 1 > 3) ? 3 : skew[l] + 1;
          st[l] = 3;
          mph[l] = ((lo + hi + 6) / 2) - 3;
        end else begin
          st[l] = 4;
          mph[l] = 0;
        end
      end else if (st[l] == 0) st[l] = 1;
    end
    it.cal = 1'b1;
    for (int l = 0; l < L; l++) begin
      logic [31:0] p32;
      p32 = 32'(mph[l]);
      it.w[l*B +: B]   = (st[l] == 1 || st[l] == 2) ? '0 : dw[l];
      it.ph[l*PW +: PW] = p32[PW-1:0];
      it.err[l]        = (st[l] == 4);
      if (st[l] != 3) it.cal = 1'b0;
    end
    exp_q.push_back(it);
    req_q.push_back(cur_req);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_t it;
        string rq;
        it = exp_q.pop_front();
        rq = req_q.pop_front();
        chk(word == it.w, {rq, " R10"}, "word", 64'(word), 64'(it.w));
        chk(phase == it.ph, {rq, " R4"}, "phase", 64'(phase), 64'(it.ph));
        chk(lerr == it.err, {rq, " R6"}, "lane_err", 64'(lerr), 64'(it.err));
        chk(cal == it.cal, {rq, " R7"}, "cal", 64'(cal), 64'(it.cal));
      end
    end
  end

  task automatic set_skew(int a, int b, int c, int d);
    skew[0] = a; skew[1] = b; skew[2] = c; skew[3] = d;
  endtask

  initial begin
    for (int l = 0; l < L; l++) begin skew[l] = 0; bad[l] = 0; st[l] = 0; mph[l] = 0; end
    #12;
    // R11: reset state
    chk(word == '0, "R11", "word", 64'(word), 64'(0));
    chk(phase == '0, "R11", "phase", 64'(phase), 64'(0));
    chk(lerr == '0 && cal == 1'b0, "R11", "err/cal", 64'({lerr, cal}), 64'(0));
    @(negedge clk);
    rst_n = 1'b1;

    // R8 R2: bypass reads at nominal strobe
    cur_req = "R8 R2";
    set_skew(0, 1, -1, 0);
    repeat (5) drive(1'b0, 1'b0);

    // R5: enabled but untrained holds zero
    cur_req = "R5";
    repeat (3) drive(1'b1, 1'b0);

    // R1 R3 R4: independent lanes, edge skews
    cur_req = "R1 R3 R4";
    set_skew(0, 2, -3, 3);
    repeat (6) drive(1'b1, 1'b1);
    cur_req = "R1 R10";
    repeat (8) drive(1'b1, 1'b0);

    // R9 R6: retrain with lane 1 carrying no pattern
    cur_req = "R9 R6";
    set_skew(-1, 1, -2, 1);
    bad[1] = 1;
    repeat (5) drive(1'b1, 1'b1);
    repeat (6) drive(1'b1, 1'b0);
    bad[1] = 0;

    // R3: four matching clocks are enough
    cur_req = "R3 R9";
    set_skew(0, -1, 1, 2);
    repeat (4) drive(1'b1, 1'b1);
    repeat (4) drive(1'b1, 1'b0);

    // R3 R6: three clocks are not
    cur_req = "R3 R6";
    set_skew(0, -1, 1, 0);
    repeat (3) drive(1'b1, 1'b1);
    repeat (4) drive(1'b1, 1'b0);

    // R7 R8: relock then disable
    cur_req = "R7";
    repeat (5) drive(1'b1, 1'b1);
    repeat (3) drive(1'b1, 1'b0);
    cur_req = "R8 R7";
    repeat (4) drive(1'b0, 1'b0);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule